// File: doc/BRIEF.md
# Store Queue Writeback Controller

This block keeps a circular queue of stores between dispatch and the data cache. Dispatch allocates a slot at the tail and receives its slot number. The execute stage later fills in the access size, whether the access crosses a line and needs two requests, and for locked (conditional) stores whether the lock is still held. Commit passes the youngest retired sequence number. The queue then marks, in queue order, the stores that are now allowed to write to memory.

A writeback pointer, kept apart from the head, walks the marked stores and presents them on a set of parallel cache request lanes. No more than one lane is used per cache port in a cycle. Completions from the cache can arrive in any order. The head frees every completed store it can reach in one cycle. A squash trims uncommitted younger stores from the tail. A cache rejection puts the queue into a held state. It leaves that state only through the retry input.

Top module: `store_wb_queue`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `full` is 0, `wb_waiting` is 0, `store_blocked` is 0 and no request lane is valid.
- R2: An allocation writes the slot reported on `alloc_idx`. Slot numbers run upward and wrap over ENTRIES+1 slots. `full` is 1 once ENTRIES stores are held. An allocation while full, or in a cycle with `squash_valid`, changes nothing.
- R3: A commit walks from the head toward the tail. It marks each unmarked store whose sequence number is not above `commit_seq` and stops at the first unmarked store that is younger. Each mark adds one to `wb_waiting`.
- R4: A store with kind 2 (conditional) marks itself when it is executed, with no commit, and adds one to `wb_waiting`.
- R5: Marked stores leave in queue order from the writeback pointer. Lane 0 is filled first. At most PORTS lanes are valid in a cycle.
- R6: `req_cmd` of a lane equals the store kind: 0 plain write, 1 swap, 2 conditional.
- R7: A split store presents its low half (`req_high`=0) and then its high half (`req_high`=1). If no lane is left for the high half, it is presented alone on lane 0 in the next cycle, before any other store.
- R8: Completions may arrive out of order and each one lowers `wb_waiting`. The head passes every consecutive completed store in one cycle and `occupancy` drops by that number.
- R9: A store of size 0 completes without a request and takes no lane.
- R10: When a lane is valid while `cache_ready` is 0, the queue sets `store_blocked` and shows no request until `cache_retry`. It then presents the same request on lane 0. It resumes only after that request is accepted.
- R11: A conditional store executed with `exec_lock_ok`=0 completes without any request.
- R12: A squash removes stores younger than `squash_seq` from the tail backward. It stops at the first store that is already marked, and `alloc_idx` returns to the new tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQW | Sequence number of the new store |
| alloc_kind | input | 2 | 0 write, 1 swap, 2 conditional |
| alloc_idx | output | IW | Slot the next allocation takes |
| full | output | 1 | ENTRIES stores held |
| exec_valid | input | 1 | Store execution result valid |
| exec_idx | input | IW | Slot being executed |
| exec_size | input | SZW | Access size in bytes, 0 for none |
| exec_split | input | 1 | Access needs two requests |
| exec_lock_ok | input | 1 | Lock still held (conditional stores) |
| commit_valid | input | 1 | Commit update |
| commit_seq | input | SEQW | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQW | Stores younger than this are removed |
| req_valid | output | PORTS | Per-lane request valid |
| req_idx | output | PORTS*IW | Per-lane slot number |
| req_high | output | PORTS | Per-lane high-half flag |
| req_cmd | output | PORTS*2 | Per-lane command |
| cache_ready | input | 1 | Cache accepts all valid lanes this cycle |
| cache_retry | input | 1 | Cache can take the held request again |
| cpl_valid | input | 1 | Cache completion for a store |
| cpl_idx | input | IW | Slot that completed |
| occupancy | output | CW | Stores held |
| wb_waiting | output | CW | Marked stores not yet completed |
| store_blocked | output | 1 | Held after a cache rejection |

## Verification
The assertions check on every cycle that occupancy never exceeds ENTRIES and that the marked-but-incomplete count never exceeds occupancy. They also check that a blocked queue shows no request without a retry, and that a pending high half always sits on lane 0. The bench scenarios cover the rest: commit stopping at a younger store, commands per kind, the split store that runs out of lanes, zero-size and failed conditional stores that complete silently, out-of-order completion freeing two slots at once, the reject-retry sequence and a squash that halts at a committed store. Those depend on particular orderings of input events and cannot be stated as one invariant per cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
    // Store kind; the cache command is the same encoding.
    typedef enum logic [1:0] {
        SQ_WRITE = 2'd0,
        SQ_SWAP  = 2'd1,
        SQ_COND  = 2'd2
    } sq_kind_e;
endpackage

// File: rtl/sq_commit_scan.sv
// Commit scan: from head toward tail, marks unmarked stores with sequence
// number not above the committed youngest, stopping at the first younger
// unmarked one. Assumes sequence numbers do not wrap inside the queue.
module sq_commit_scan #(
    parameter int S    = 5,
    parameter int IW   = 3,
    parameter int SEQW = 8
) (
    input  logic            en,
    input  logic [IW-1:0]   head,
    input  logic [IW-1:0]   tail,
    input  logic [S-1:0]    canwb,
    input  logic [SEQW-1:0] seq [S],
    input  logic [SEQW-1:0] cseq,
    output logic [S-1:0]    mark
);
    function automatic logic [IW-1:0] nx(input logic [IW-1:0] i);
        return (i == IW'(S-1)) ? '0 : i + 1'b1;
    endfunction

    // Walk the queue once in order and collect the marks.
    always_comb begin
        logic [IW-1:0] p;
        logic          go;
        mark = '0;
        p    = head;
        go   = en;
        for (int i = 0; i < S; i++) begin
            if (go && p != tail) begin
                if (!canwb[p]) begin
                    if (seq[p] > cseq) go = 1'b0;
                    else               mark[p] = 1'b1;
                end
                p = nx(p);
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sq_squash_walk.sv
// Squash walk: backward from tail, removes stores younger than the squash
// number and stops at the head or at the first store marked for writeback.
module sq_squash_walk #(
    parameter int S    = 5,
    parameter int IW   = 3,
    parameter int SEQW = 8
) (
    input  logic            en,
    input  logic [IW-1:0]   head,
    input  logic [IW-1:0]   tail,
    input  logic [S-1:0]    canwb,
    input  logic [SEQW-1:0] seq [S],
    input  logic [SEQW-1:0] sseq,
    output logic [S-1:0]    kill,
    output logic [IW-1:0]   new_tail
);
    function automatic logic [IW-1:0] pv(input logic [IW-1:0] i);
        return (i == '0) ? IW'(S-1) : i - 1'b1;
    endfunction

    // Step back from the tail while the entry may be removed.
    always_comb begin
        logic [IW-1:0] p;
        logic [IW-1:0] e;
        logic          go;
        kill = '0;
        p    = tail;
        go   = en;
        for (int i = 0; i < S; i++) begin
            e = pv(p);
            if (go && p != head && seq[e] > sseq && !canwb[e]) begin
                kill[e] = 1'b1;
                p = e;
            end else begin
                go = 1'b0;
            end
        end
        new_tail = p;
    end
endmodule

// File: rtl/sq_issue_plan.sv
// Issue planner: from the writeback pointer, fills request lanes in order
// under the per-cycle port budget. Zero-size and failed conditional stores
// complete here without a lane. When blocked, only the held request is shown,
// and only while retry is high. Assumes marked stores have been executed.
module sq_issue_plan #(
    parameter int S   = 5,
    parameter int IW  = 3,
    parameter int P   = 2,
    parameter int SZW = 4
) (
    input  logic [IW-1:0]        wb,
    input  logic [IW-1:0]        tail,
    input  logic [S-1:0]         canwb,
    input  logic [SZW-1:0]       size [S],
    input  logic [S-1:0]         split,
    input  logic [S-1:0]         lockf,
    input  logic [1:0]           kind [S],
    input  logic                 pend,
    input  logic                 blocked,
    input  logic                 held_hi,
    input  logic                 retry,
    output logic [P-1:0]         lane_vld,
    output logic [P-1:0][IW-1:0] lane_idx,
    output logic [P-1:0]         lane_hi,
    output logic [P-1:0][1:0]    lane_cmd,
    output logic [IW-1:0]        wb_after,
    output logic                 pend_after,
    output logic [S-1:0]         cpl_int,
    output logic [S-1:0]         cpl_pre
);
    function automatic logic [IW-1:0] nx(input logic [IW-1:0] i);
        return (i == IW'(S-1)) ? '0 : i + 1'b1;
    endfunction

    // Build this cycle's lane contents and the pointer state that follows.
    always_comb begin
        logic [IW-1:0] p;
        logic          go;
        int            used;
        lane_vld   = '0;
        lane_idx   = '0;
        lane_hi    = '0;
        lane_cmd   = '0;
        cpl_int    = '0;
        cpl_pre    = '0;
        pend_after = 1'b0;
        p          = wb;
        used       = 0;
        go         = !blocked;
        if (blocked && retry) begin
            lane_vld[0] = 1'b1;
            lane_idx[0] = wb;
            lane_hi[0]  = held_hi;
            lane_cmd[0] = kind[wb];
        end
        if (!blocked && pend) begin
            lane_vld[0] = 1'b1;
            lane_idx[0] = wb;
            lane_hi[0]  = 1'b1;
            lane_cmd[0] = kind[wb];
            used        = 1;
            p           = nx(wb);
        end
        for (int i = 0; i < S; i++) begin
            if (go && used < P && p != tail && canwb[p]) begin
                if (size[p] == '0 || lockf[p]) begin
                    cpl_int[p] = 1'b1;
                    if (used == 0) cpl_pre[p] = 1'b1;
                    p = nx(p);
                end else begin
                    for (int k = 0; k < P; k++) begin
                        if (k == used) begin
                            lane_vld[k] = 1'b1;
                            lane_idx[k] = p;
                            lane_cmd[k] = kind[p];
                        end
                    end
                    used = used + 1;
                    if (split[p]) begin
                        if (used < P) begin
                            for (int k = 0; k < P; k++) begin
                                if (k == used) begin
                                    lane_vld[k] = 1'b1;
                                    lane_idx[k] = p;
                                    lane_hi[k]  = 1'b1;
                                    lane_cmd[k] = kind[p];
                                end
                            end
                            used = used + 1;
                            p = nx(p);
                        end else begin
                            pend_after = 1'b1;
                            go = 1'b0;
                        end
                    end else begin
                        p = nx(p);
                    end
                end
            end else begin
                go = 1'b0;
            end
        end
        wb_after = p;
    end
endmodule

// File: rtl/store_wb_queue.sv
// Store queue writeback controller. Holds stores from dispatch until the
// cache completes them, with separate head, writeback and tail pointers over
// ENTRIES+1 slots. Assumes: no commit beyond a squash point in the same
// cycle, completions name issued stores, exec never targets a free slot.
module store_wb_queue
    import sq_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PORTS   = 2,
    parameter int SEQW    = 8,
    parameter int SZW     = 4,
    localparam int S      = ENTRIES + 1,
    localparam int IW     = $clog2(S),
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [SEQW-1:0]    alloc_seq,
    input  logic [1:0]         alloc_kind,
    output logic [IW-1:0]      alloc_idx,
    output logic               full,
    input  logic               exec_valid,
    input  logic [IW-1:0]      exec_idx,
    input  logic [SZW-1:0]     exec_size,
    input  logic               exec_split,
    input  logic               exec_lock_ok,
    input  logic               commit_valid,
    input  logic [SEQW-1:0]    commit_seq,
    input  logic               squash_valid,
    input  logic [SEQW-1:0]    squash_seq,
    output logic [PORTS-1:0]   req_valid,
    output logic [PORTS*IW-1:0] req_idx,
    output logic [PORTS-1:0]   req_high,
    output logic [PORTS*2-1:0] req_cmd,
    input  logic               cache_ready,
    input  logic               cache_retry,
    input  logic               cpl_valid,
    input  logic [IW-1:0]      cpl_idx,
    output logic [CW-1:0]      occupancy,
    output logic [CW-1:0]      wb_waiting,
    output logic               store_blocked
);
    function automatic logic [IW-1:0] nx(input logic [IW-1:0] i);
        return (i == IW'(S-1)) ? '0 : i + 1'b1;
    endfunction

    logic [IW-1:0]   head_q, tail_q, wb_q;
    logic [CW-1:0]   occ_q, wait_q;
    logic            blk_q, pend_q, hh_q;
    logic [S-1:0]    canwb_q, done_q, split_q, lockf_q;
    logic [SEQW-1:0] seq_q  [S];
    logic [1:0]      kind_q [S];
    logic [SZW-1:0]  size_q [S];

    logic               do_alloc, do_commit, exec_sc;
    logic [S-1:0]       exec_oh, mark, mark_eff, kill, cpl_int, cpl_pre;
    logic [S-1:0]       cpl_apply, cpl_vec, done_n, free_v;
    logic [IW-1:0]      sq_tail, wb_after, wb_n, head_n;
    logic               pend_after, pend_n, blk_n, hh_n;
    logic [PORTS-1:0]   lane_vld, lane_hi;
    logic [PORTS-1:0][IW-1:0] lane_idx;
    logic [PORTS-1:0][1:0]    lane_cmd;
    logic [CW-1:0]      freed;

    assign do_alloc  = alloc_valid && !full && !squash_valid;
    assign do_commit = commit_valid && !squash_valid;
    assign exec_oh   = exec_valid ? (S'(1) << exec_idx) : '0;
    assign exec_sc   = exec_valid && kind_q[exec_idx] == SQ_COND && !canwb_q[exec_idx];
    assign mark_eff  = mark & ~(exec_sc ? exec_oh : '0);

    sq_commit_scan #(.S(S), .IW(IW), .SEQW(SEQW)) u_scan (
        .en(do_commit), .head(head_q), .tail(tail_q), .canwb(canwb_q),
        .seq(seq_q), .cseq(commit_seq), .mark(mark));

    sq_squash_walk #(.S(S), .IW(IW), .SEQW(SEQW)) u_squash (
        .en(squash_valid), .head(head_q), .tail(tail_q), .canwb(canwb_q),
        .seq(seq_q), .sseq(squash_seq), .kill(kill), .new_tail(sq_tail));

    sq_issue_plan #(.S(S), .IW(IW), .P(PORTS), .SZW(SZW)) u_plan (
        .wb(wb_q), .tail(tail_q), .canwb(canwb_q), .size(size_q),
        .split(split_q), .lockf(lockf_q), .kind(kind_q), .pend(pend_q),
        .blocked(blk_q), .held_hi(hh_q), .retry(cache_retry),
        .lane_vld(lane_vld), .lane_idx(lane_idx), .lane_hi(lane_hi),
        .lane_cmd(lane_cmd), .wb_after(wb_after), .pend_after(pend_after),
        .cpl_int(cpl_int), .cpl_pre(cpl_pre));

    // Resolve the cache handshake into next pointer and blocked state.
    always_comb begin
        wb_n      = wb_q;
        pend_n    = pend_q;
        blk_n     = blk_q;
        hh_n      = hh_q;
        cpl_apply = '0;
        if (blk_q) begin
            if (cache_retry && cache_ready) begin
                blk_n = 1'b0;
                if (hh_q || !split_q[wb_q]) wb_n = nx(wb_q);
                else                        pend_n = 1'b1;
            end
        end else if (lane_vld != '0 && !cache_ready) begin
            blk_n     = 1'b1;
            hh_n      = lane_hi[0];
            wb_n      = lane_idx[0];
            pend_n    = 1'b0;
            cpl_apply = cpl_pre;
        end else begin
            wb_n      = wb_after;
            pend_n    = pend_after;
            cpl_apply = cpl_int;
        end
    end

    assign cpl_vec = cpl_apply | (cpl_valid ? (S'(1) << cpl_idx) : '0);
    assign done_n  = done_q | cpl_vec;

    // Advance the head over every consecutive completed store.
    always_comb begin
        logic [IW-1:0] p;
        logic          go;
        free_v = '0;
        freed  = '0;
        p      = head_q;
        go     = 1'b1;
        for (int i = 0; i < S; i++) begin
            if (go && p != tail_q && done_n[p]) begin
                free_v[p] = 1'b1;
                freed     = freed + 1'b1;
                p         = nx(p);
            end else begin
                go = 1'b0;
            end
        end
        head_n = p;
    end

    // Pointer, counter and per-slot flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            wb_q    <= '0;
            occ_q   <= '0;
            wait_q  <= '0;
            blk_q   <= 1'b0;
            pend_q  <= 1'b0;
            hh_q    <= 1'b0;
            canwb_q <= '0;
            done_q  <= '0;
        end else begin
            head_q  <= head_n;
            tail_q  <= squash_valid ? sq_tail : (do_alloc ? nx(tail_q) : tail_q);
            wb_q    <= wb_n;
            blk_q   <= blk_n;
            pend_q  <= pend_n;
            hh_q    <= hh_n;
            occ_q   <= occ_q + CW'(do_alloc) - freed - CW'($countones(kill));
            wait_q  <= wait_q + CW'($countones(mark_eff)) + CW'(exec_sc)
                       - CW'($countones(cpl_vec));
            canwb_q <= (canwb_q | mark_eff | (exec_sc ? exec_oh : '0)) & ~free_v & ~kill;
            done_q  <= done_n & ~free_v;
        end
    end

    // Per-slot payload written at allocation and execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q <= '0;
            lockf_q <= '0;
            for (int i = 0; i < S; i++) begin
                seq_q[i]  <= '0;
                kind_q[i] <= SQ_WRITE;
                size_q[i] <= '0;
            end
        end else begin
            if (do_alloc) begin
                seq_q[tail_q]  <= alloc_seq;
                kind_q[tail_q] <= alloc_kind;
            end
            if (exec_valid) begin
                size_q[exec_idx]  <= exec_size;
                split_q[exec_idx] <= exec_split;
                lockf_q[exec_idx] <= !exec_lock_ok;
            end
        end
    end

    assign alloc_idx     = tail_q;
    assign full          = occ_q == CW'(ENTRIES);
    assign occupancy     = occ_q;
    assign wb_waiting    = wait_q;
    assign store_blocked = blk_q;
    assign req_valid     = lane_vld;
    assign req_idx       = lane_idx;
    assign req_high      = lane_hi;
    assign req_cmd       = lane_cmd;

    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(ENTRIES));
    a_r3_waiting_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= occ_q);
    a_r10_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q && !cache_retry |-> req_valid == '0);
    a_r7_pending_first: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !blk_q |-> req_valid[0] && req_high[0]);
endmodule

// File: tb/store_wb_queue_bench.sv
module store_wb_queue_bench;
    localparam int ENTRIES = 4;
    localparam int PORTS   = 2;
    localparam int SEQW    = 8;
    localparam int SZW     = 4;
    localparam int IW      = 3;
    localparam int CW      = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0; logic [SEQW-1:0] alloc_seq = 0; logic [1:0] alloc_kind = 0;
    logic [IW-1:0] alloc_idx; logic full;
    logic exec_valid = 0; logic [IW-1:0] exec_idx = 0; logic [SZW-1:0] exec_size = 0;
    logic exec_split = 0; logic exec_lock_ok = 1;
    logic commit_valid = 0; logic [SEQW-1:0] commit_seq = 0;
    logic squash_valid = 0; logic [SEQW-1:0] squash_seq = 0;
    logic [PORTS-1:0] req_valid, req_high;
    logic [PORTS*IW-1:0] req_idx;
    logic [PORTS*2-1:0] req_cmd;
    logic cache_ready = 1, cache_retry = 0, cpl_valid = 0;
    logic [IW-1:0] cpl_idx = 0;
    logic [CW-1:0] occupancy, wb_waiting;
    logic store_blocked;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    store_wb_queue #(.ENTRIES(ENTRIES), .PORTS(PORTS), .SEQW(SEQW), .SZW(SZW)) u_store_wb_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_kind(alloc_kind),
        .alloc_idx(alloc_idx), .full(full),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_size(exec_size),
        .exec_split(exec_split), .exec_lock_ok(exec_lock_ok),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .req_valid(req_valid), .req_idx(req_idx), .req_high(req_high), .req_cmd(req_cmd),
        .cache_ready(cache_ready), .cache_retry(cache_retry),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .occupancy(occupancy), .wb_waiting(wb_waiting), .store_blocked(store_blocked));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lidx(input int k); return int'(req_idx[k*IW +: IW]); endfunction
    function automatic int lcmd(input int k); return int'(req_cmd[k*2 +: 2]); endfunction

    // Advance one clock; inputs change just after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Mid-cycle settle point for sampling combinational outputs.
    task automatic mid();
        #2;
    endtask

    task automatic do_alloc(input int s, input int k, input int exp_idx);
        alloc_valid = 1; alloc_seq = SEQW'(s); alloc_kind = 2'(k);
        mid();
        chk("R2 alloc_idx", int'(alloc_idx), exp_idx);
        tick();
        alloc_valid = 0;
    endtask

    task automatic do_exec(input int i, input int sz, input bit sp, input bit ok);
        exec_valid = 1; exec_idx = IW'(i); exec_size = SZW'(sz); exec_split = sp; exec_lock_ok = ok;
        tick();
        exec_valid = 0; exec_lock_ok = 1;
    endtask

    task automatic do_commit(input int s);
        commit_valid = 1; commit_seq = SEQW'(s);
        tick();
        commit_valid = 0;
    endtask

    task automatic do_cpl(input int i);
        cpl_valid = 1; cpl_idx = IW'(i);
        tick();
        cpl_valid = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        repeat (3) tick();
        rst_n = 1;
        mid();
        // R1 reset state
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 wb_waiting", int'(wb_waiting), 0);
        chk("R1 blocked", int'(store_blocked), 0);
        chk("R1 req_valid", int'(req_valid), 0);

        // R2 fill and overflow
        do_alloc(10, 0, 0);
        do_alloc(11, 1, 1);
        do_alloc(12, 0, 2);
        do_alloc(13, 0, 3);
        chk("R2 full", int'(full), 1);
        alloc_valid = 1; alloc_seq = 14; tick(); alloc_valid = 0;
        chk("R2 occupancy after ignored alloc", int'(occupancy), 4);
        chk("R2 tail unchanged", int'(alloc_idx), 4);

        do_exec(0, 4, 0, 1);
        do_exec(1, 4, 0, 1);
        do_exec(2, 4, 1, 1);
        do_exec(3, 0, 0, 1);
        mid();
        chk("R3 nothing issued before commit", int'(req_valid), 0);

        // R3 commit stops at seq 12
        do_commit(11);
        chk("R3 waiting after commit", int'(wb_waiting), 2);
        mid();
        // R5/R6 two lanes, in order, write then swap
        chk("R5 lanes valid", int'(req_valid), 3);
        chk("R5 lane0 idx", lidx(0), 0);
        chk("R5 lane1 idx", lidx(1), 1);
        chk("R6 lane0 cmd write", lcmd(0), 0);
        chk("R6 lane1 cmd swap", lcmd(1), 1);
        tick();
        mid();
        chk("R3 unmarked store not issued", int'(req_valid), 0);

        // R8 out-of-order completion
        do_cpl(1);
        chk("R8 occupancy held by head", int'(occupancy), 4);
        chk("R8 waiting after one cpl", int'(wb_waiting), 1);
        do_cpl(0);
        chk("R8 two freed at once", int'(occupancy), 2);
        chk("R8 waiting zero", int'(wb_waiting), 0);
        chk("R8 not full", int'(full), 0);

        // R7 split in one cycle, R9 zero-size
        do_commit(13);
        chk("R3 waiting after second commit", int'(wb_waiting), 2);
        mid();
        chk("R7 split lanes", int'(req_valid), 3);
        chk("R7 lane0 idx", lidx(0), 2);
        chk("R7 lane1 idx", lidx(1), 2);
        chk("R7 halves", int'(req_high), 2);
        tick();
        mid();
        chk("R9 zero-size no request", int'(req_valid), 0);
        tick();
        chk("R9 zero-size completed", int'(wb_waiting), 1);
        chk("R9 occupancy kept by head", int'(occupancy), 2);
        do_cpl(2);
        chk("R8 head passes 2 and 3", int'(occupancy), 0);
        chk("R9 waiting zero", int'(wb_waiting), 0);

        // R7 high half deferred; R2 wrap
        do_alloc(20, 0, 4);
        do_alloc(21, 0, 0);
        do_exec(4, 4, 0, 1);
        do_exec(0, 8, 1, 1);
        do_commit(21);
        mid();
        chk("R7 two lanes used", int'(req_valid), 3);
        chk("R7 lane0 idx4", lidx(0), 4);
        chk("R7 lane1 low of 0", lidx(1), 0);
        chk("R7 both low", int'(req_high), 0);
        tick();
        mid();
        chk("R7 pending alone", int'(req_valid), 1);
        chk("R7 pending idx", lidx(0), 0);
        chk("R7 pending is high", int'(req_high[0]), 1);
        tick();
        mid();
        chk("R7 nothing after pending", int'(req_valid), 0);
        do_cpl(4);
        do_cpl(0);
        chk("R8 empty again", int'(occupancy), 0);

        // R10 reject and retry
        do_alloc(30, 0, 1);
        do_exec(1, 4, 0, 1);
        do_commit(30);
        cache_ready = 0;
        mid();
        chk("R10 offered", int'(req_valid), 1);
        tick();
        chk("R10 blocked", int'(store_blocked), 1);
        mid();
        chk("R10 quiet while blocked", int'(req_valid), 0);
        tick();
        cache_retry = 1;
        mid();
        chk("R10 resend on retry", int'(req_valid), 1);
        chk("R10 resend idx", lidx(0), 1);
        tick();
        chk("R10 still blocked", int'(store_blocked), 1);
        cache_ready = 1;
        mid();
        chk("R10 resend again", lidx(0), 1);
        tick();
        cache_retry = 0;
        chk("R10 unblocked", int'(store_blocked), 0);
        mid();
        chk("R10 no duplicate", int'(req_valid), 0);
        do_cpl(1);
        chk("R10 freed", int'(occupancy), 0);

        // R4 conditional store self-marks
        do_alloc(40, 2, 2);
        do_exec(2, 4, 0, 1);
        chk("R4 waiting without commit", int'(wb_waiting), 1);
        mid();
        chk("R4 issued", int'(req_valid), 1);
        chk("R6 cmd conditional", lcmd(0), 2);
        tick();
        do_cpl(2);
        chk("R4 freed", int'(occupancy), 0);

        // R11 failed conditional completes silently
        do_alloc(41, 2, 3);
        do_exec(3, 4, 0, 0);
        chk("R11 waiting", int'(wb_waiting), 1);
        mid();
        chk("R11 no request", int'(req_valid), 0);
        tick();
        chk("R11 completed", int'(wb_waiting), 0);
        chk("R11 freed", int'(occupancy), 0);

        // R12 squash stops at a committed store
        do_alloc(50, 0, 4);
        do_alloc(51, 0, 0);
        do_alloc(52, 0, 1);
        do_exec(4, 4, 0, 1);
        do_exec(0, 4, 0, 1);
        do_exec(1, 4, 0, 1);
        do_commit(50);
        squash_valid = 1; squash_seq = 49;
        tick();
        squash_valid = 0;
        chk("R12 occupancy", int'(occupancy), 1);
        chk("R12 tail", int'(alloc_idx), 0);
        chk("R12 waiting kept", int'(wb_waiting), 1);
        do_cpl(4);
        chk("R12 empty", int'(occupancy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule